// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the state of a small, fixed set of interrupt sources and offers their interrupts to a presentation unit. Each source is either edge-type (message-style: a rising input is an event) or level-type (the input is a condition that holds until cleared), chosen per source by a parameter bit. Every source holds a destination server number, a priority and a few status bits. A priority of 0xFF means the source is masked.

Software or a management agent programs a source through a single-cycle configuration write that sets its server and priority. The presentation unit talks back with three notifications. A reject carries a global source number and says the offer was refused. An end-of-interrupt carries a global source number and says the interrupt was serviced. A resend request asks the block to walk every source and replay what is owed. Offers leave the block one per cycle as a global source number (local index plus a base parameter), a server and a priority.

Edge-type sources remember an event that arrived while masked, and remember a refused offer, and replay either one later. Level-type sources offer while asserted and unmasked, and do not repeat while an earlier offer is still in service.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset every source has priority 0xFF (masked) and all status cleared, offer_valid is 0 and scan_busy is 0. The type of source i is fixed by bit i of LEVEL_MAP (1 = level-type, 0 = edge-type) and is not changed by reset.
- R2: A rising src_line[i] on an unmasked edge-type source produces exactly one offer with offer_num = BASE + i and the source's server and priority. offer_valid is high for one cycle, after the second rising clock edge counting the edge that samples the new input.
- R3: A rising input on a masked edge-type source produces no offer and records a masked-pending event. A later configuration write that gives the source a priority other than 0xFF replays it as one offer and clears it, so a further write produces no offer.
- R4: A level-type source is offered when it is unmasked, its input is high and it is not marked sent. The source is re-examined on every input change, and offering marks it sent. While it is marked sent it is not offered again.
- R5: A reject naming an edge-type source marks it rejected. The next resend scan clears the mark and re-offers the source if it is unmasked. A reject naming a level-type source clears its sent mark, so the next resend re-offers it if it is still high and unmasked.
- R6: An end-of-interrupt clears the sent mark of a level-type source but causes no offer by itself. It has no effect on an edge-type source.
- R7: Reject and end-of-interrupt numbers outside BASE .. BASE+N_SRC-1 change no source.
- R8: At most one offer leaves per cycle. When several sources owe an offer, the lowest local index goes first and the others follow in later cycles.
- R9: A resend request starts a scan that visits one source per cycle from index 0 upward while scan_busy is high. A request that arrives during a scan is remembered and starts one more full scan straight after the current one.
- R10: A configuration write replaces the server and priority of source cfg_idx. For a level-type source it then reapplies the offer rule of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_line | input | N_SRC | Per-source interrupt input lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the source being configured |
| cfg_server | input | SRV_W | New destination server |
| cfg_prio | input | 8 | New priority, 0xFF masks |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | NUM_W | Global number of the rejected source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number of the serviced source |
| resend_req | input | 1 | Request to replay all owed offers |
| offer_valid | output | 1 | An offer is presented this cycle |
| offer_num | output | NUM_W | Global source number of the offer |
| offer_server | output | SRV_W | Destination server of the offer |
| offer_prio | output | 8 | Priority of the offer |
| scan_busy | output | 1 | Resend scan in progress |

## Verification
The bench builds the block with four sources, BASE = 0x100, a 12-bit number width and LEVEL_MAP = 4'b1100, so sources 0 and 1 are edge-type and 2 and 3 are level-type. With only four sources, a full resend scan takes four cycles. That makes it practical to issue a second resend request in the middle of a scan and see the queued rescan replay a source a second time. It also makes 0x0FF and 0x104 the two out-of-range numbers on either side of the window. Raising both edge-type inputs in the same cycle exercises the lowest-index ordering. The expected order of offers is predicted in a scoreboard queue.

// File: rtl/xsrc_pkg.sv
package xsrc_pkg;
    localparam int PRIO_W = 8;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_OFF = '1;
endpackage

// File: rtl/src_slot.sv
module src_slot
    import xsrc_pkg::*;
#(
    parameter int SRV_W    = 4,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  logic             rej_hit,
    input  logic             eoi_hit,
    input  logic             cfg_hit,
    input  logic [SRV_W-1:0] cfg_server,
    input  prio_t            cfg_prio,
    input  logic             scan_hit,
    input  logic             grant,
    output logic             req,
    output logic [SRV_W-1:0] server,
    output prio_t            prio
);
    typedef struct packed {
        logic             prev;
        logic             asserted;
        logic             sent;
        logic             rejected;
        logic             mpend;
        logic             req;
        logic [SRV_W-1:0] server;
        prio_t            prio;
    } slot_t;

    slot_t s_d, s_q;
    logic  unmasked;

    always_comb begin
        s_d = s_q;
        if (grant) s_d.req = 1'b0;
        if (cfg_hit) begin
            s_d.server = cfg_server;
            s_d.prio   = cfg_prio;
        end
        unmasked = (s_d.prio != PRIO_OFF);
        if (IS_LEVEL) begin
            s_d.asserted = line;
            if (rej_hit || eoi_hit) s_d.sent = 1'b0;
            if ((line != s_q.asserted || cfg_hit || scan_hit)
                && unmasked && line && !s_d.sent) begin
                s_d.sent = 1'b1;
                s_d.req  = 1'b1;
            end
        end else begin
            s_d.prev = line;
            if (rej_hit) s_d.rejected = 1'b1;
            if (line && !s_q.prev) begin
                if (unmasked) s_d.req   = 1'b1;
                else          s_d.mpend = 1'b1;
            end
            if (cfg_hit && s_d.mpend && unmasked) begin
                s_d.mpend = 1'b0;
                s_d.req   = 1'b1;
            end
            if (scan_hit && s_d.rejected) begin
                s_d.rejected = 1'b0;
                if (unmasked) s_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.prio <= PRIO_OFF;
        end else begin
            s_q <= s_d;
        end
    end

    assign req    = s_q.req;
    assign server = s_q.server;
    assign prio   = s_q.prio;

    AST_SENT_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.sent) |-> s_q.req); // R4
    AST_MPEND_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.mpend |-> (s_q.prio == PRIO_OFF)); // R3
endmodule

// File: rtl/offer_arb.sv
module offer_arb
    import xsrc_pkg::*;
#(
    parameter int               N_SRC = 8,
    parameter int               SRV_W = 4,
    parameter int               NUM_W = 16,
    parameter logic [NUM_W-1:0] BASE  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic [SRV_W-1:0] server [N_SRC],
    input  prio_t            prio   [N_SRC],
    output logic [N_SRC-1:0] grant,
    output logic             offer_valid,
    output logic [NUM_W-1:0] offer_num,
    output logic [SRV_W-1:0] offer_server,
    output prio_t            offer_prio
);
    typedef struct packed {
        logic             valid;
        logic [NUM_W-1:0] num;
        logic [SRV_W-1:0] server;
        prio_t            prio;
    } offer_t;

    offer_t out_d, out_q;
    logic   found;

    always_comb begin
        out_d = '0;
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (!found && req[i]) begin
                found        = 1'b1;
                grant[i]     = 1'b1;
                out_d.valid  = 1'b1;
                out_d.num    = BASE + NUM_W'(i);
                out_d.server = server[i];
                out_d.prio   = prio[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign offer_valid  = out_q.valid;
    assign offer_num    = out_q.num;
    assign offer_server = out_q.server;
    assign offer_prio   = out_q.prio;

    AST_OFFER_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.valid |-> $past(|req)); // R8
endmodule

// File: rtl/resend_scan.sv
module resend_scan #(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [N_SRC-1:0] hit
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SRC - 1);

    typedef struct packed {
        logic             busy;
        logic             rerun;
        logic [IDX_W-1:0] ptr;
    } scan_t;

    scan_t q, d;

    always_comb begin
        d   = q;
        hit = '0;
        if (q.busy) begin
            hit[q.ptr] = 1'b1;
            if (start) d.rerun = 1'b1;
            if (q.ptr == LAST) begin
                d.ptr   = '0;
                d.busy  = q.rerun | start;
                d.rerun = 1'b0;
            end else begin
                d.ptr = q.ptr + 1'b1;
            end
        end else if (start) begin
            d.busy = 1'b1;
            d.ptr  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;

    AST_SCAN_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.ptr != '0) |-> (q.ptr == IDX_W'($past(q.ptr) + 1'b1))); // R9
    AST_RERUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.ptr == LAST && q.rerun) |=> (q.busy && q.ptr == '0)); // R9
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
    import xsrc_pkg::*;
#(
    parameter int               N_SRC     = 8,
    parameter int               SRV_W     = 4,
    parameter int               NUM_W     = 16,
    parameter logic [NUM_W-1:0] BASE      = 16'h1000,
    parameter logic [N_SRC-1:0] LEVEL_MAP = 8'hF0,
    localparam int              IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_line,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [SRV_W-1:0] cfg_server,
    input  logic [7:0]       cfg_prio,
    input  logic             rej_valid,
    input  logic [NUM_W-1:0] rej_num,
    input  logic             eoi_valid,
    input  logic [NUM_W-1:0] eoi_num,
    input  logic             resend_req,
    output logic             offer_valid,
    output logic [NUM_W-1:0] offer_num,
    output logic [SRV_W-1:0] offer_server,
    output logic [7:0]       offer_prio,
    output logic             scan_busy
);
    logic [N_SRC-1:0] req, grant, scan_hit;
    logic [SRV_W-1:0] srv_a  [N_SRC];
    prio_t            prio_a [N_SRC];

    resend_scan #(.N_SRC(N_SRC)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .start (resend_req),
        .busy  (scan_busy),
        .hit   (scan_hit)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic rej_hit, eoi_hit, cfg_hit;
        assign rej_hit = rej_valid && (rej_num == BASE + NUM_W'(i));
        assign eoi_hit = eoi_valid && (eoi_num == BASE + NUM_W'(i));
        assign cfg_hit = cfg_we && (cfg_idx == IDX_W'(i));

        src_slot #(.SRV_W(SRV_W), .IS_LEVEL(LEVEL_MAP[i])) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .line       (src_line[i]),
            .rej_hit    (rej_hit),
            .eoi_hit    (eoi_hit),
            .cfg_hit    (cfg_hit),
            .cfg_server (cfg_server),
            .cfg_prio   (cfg_prio),
            .scan_hit   (scan_hit[i]),
            .grant      (grant[i]),
            .req        (req[i]),
            .server     (srv_a[i]),
            .prio       (prio_a[i])
        );
    end

    offer_arb #(.N_SRC(N_SRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE(BASE)) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .server       (srv_a),
        .prio         (prio_a),
        .grant        (grant),
        .offer_valid  (offer_valid),
        .offer_num    (offer_num),
        .offer_server (offer_server),
        .offer_prio   (offer_prio)
    );
endmodule

// File: tb/sim_irq_source_ctrl.sv
module sim_irq_source_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_line = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [3:0]  cfg_server = '0;
    logic [7:0]  cfg_prio = '0;
    logic        rej_valid = 1'b0;
    logic [11:0] rej_num = '0;
    logic        eoi_valid = 1'b0;
    logic [11:0] eoi_num = '0;
    logic        resend_req = 1'b0;
    logic        offer_valid;
    logic [11:0] offer_num;
    logic [3:0]  offer_server;
    logic [7:0]  offer_prio;
    logic        scan_busy;

    always #2 clk = ~clk;

    irq_source_ctrl #(.N_SRC(4), .SRV_W(4), .NUM_W(12), .BASE(12'h100),
                      .LEVEL_MAP(4'b1100)) u0 (.*);

    typedef struct {
        logic [11:0] num;
        logic [3:0]  srv;
        logic [7:0]  prio;
        string       tag;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    fails  = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_offer(logic [11:0] num, logic [3:0] srv, logic [7:0] prio, string tag);
        exp_t e;
        e.num = num; e.srv = srv; e.prio = prio; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: pops expected offers in order
    always @(negedge clk) begin
        if (rst_n && offer_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, "unexpected offer", int'(offer_num), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(offer_num == e.num && offer_server == e.srv && offer_prio == e.prio,
                      e.tag, "offer num/server/prio",
                      int'({offer_num, offer_server, offer_prio}), int'({e.num, e.srv, e.prio}));
            end
        end
    end

    task automatic settle(int n, string tag);
        repeat (n) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, tag, "missing offers", exp_q.size(), 0);
    endtask

    task automatic set_line(int i, logic v);
        @(posedge clk); #1 src_line[i] = v;
    endtask

    task automatic do_cfg(logic [1:0] idx, logic [3:0] srv, logic [7:0] prio);
        @(posedge clk); #1 cfg_we = 1'b1; cfg_idx = idx; cfg_server = srv; cfg_prio = prio;
        @(posedge clk); #1 cfg_we = 1'b0;
    endtask

    task automatic do_rej(logic [11:0] num);
        @(posedge clk); #1 rej_valid = 1'b1; rej_num = num;
        @(posedge clk); #1 rej_valid = 1'b0;
    endtask

    task automatic do_eoi(logic [11:0] num);
        @(posedge clk); #1 eoi_valid = 1'b1; eoi_num = num;
        @(posedge clk); #1 eoi_valid = 1'b0;
    endtask

    task automatic do_resend();
        @(posedge clk); #1 resend_req = 1'b1;
        @(posedge clk); #1 resend_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(offer_valid == 1'b0, "R1", "offer_valid after reset", offer_valid, 0);
        check(scan_busy == 1'b0, "R1", "scan_busy after reset", scan_busy, 0);

        // R1 / R3: reset leaves sources masked; edge event is held
        cur_tag = "R1";
        set_line(0, 1'b1);
        settle(6, "R1");
        cur_tag = "R3";
        expect_offer(12'h100, 4'd3, 8'd5, "R3");
        do_cfg(2'd0, 4'd3, 8'd5);
        settle(6, "R3");
        do_cfg(2'd0, 4'd3, 8'd6);
        settle(6, "R3");
        set_line(0, 1'b0);

        // R2: edge offer with exact latency
        cur_tag = "R2";
        do_cfg(2'd1, 4'd2, 8'd4);
        settle(4, "R2");
        expect_offer(12'h101, 4'd2, 8'd4, "R2");
        @(posedge clk); #1 src_line[1] = 1'b1;
        @(negedge clk);
        check(offer_valid == 1'b0, "R2", "offer too early (1)", offer_valid, 0);
        @(negedge clk);
        check(offer_valid == 1'b0, "R2", "offer too early (2)", offer_valid, 0);
        @(negedge clk);
        check(offer_valid == 1'b1, "R2", "offer latency", offer_valid, 1);
        settle(4, "R2");
        set_line(1, 1'b0);

        // R4: level offer rule, no repeat while sent
        cur_tag = "R4";
        do_cfg(2'd2, 4'd1, 8'd3);
        settle(4, "R4");
        expect_offer(12'h102, 4'd1, 8'd3, "R4");
        set_line(2, 1'b1);
        settle(6, "R4");
        do_cfg(2'd2, 4'd1, 8'd3);
        settle(6, "R4");

        // R6: eoi clears sent, resend re-offers; eoi on edge source does nothing
        cur_tag = "R6";
        do_eoi(12'h102);
        settle(6, "R6");
        expect_offer(12'h102, 4'd1, 8'd3, "R6");
        do_resend();
        settle(10, "R6");
        do_eoi(12'h100);
        do_resend();
        settle(10, "R6");

        // R10: config write reapplies the level rule
        cur_tag = "R10";
        set_line(3, 1'b1);
        settle(6, "R10");
        expect_offer(12'h103, 4'd0, 8'd7, "R10");
        do_cfg(2'd3, 4'd0, 8'd7);
        settle(6, "R10");

        // R5: reject on edge and level sources, replay by resend in index order
        cur_tag = "R5";
        do_rej(12'h101);
        do_rej(12'h103);
        settle(4, "R5");
        expect_offer(12'h101, 4'd2, 8'd4, "R5");
        expect_offer(12'h103, 4'd0, 8'd7, "R5");
        do_resend();
        settle(10, "R5");

        // R7: numbers outside the window are ignored
        cur_tag = "R7";
        do_rej(12'h0FF);
        do_rej(12'h104);
        do_eoi(12'h104);
        do_eoi(12'h0FF);
        do_resend();
        settle(10, "R7");

        // R8: two simultaneous edge events, lowest index first
        cur_tag = "R8";
        expect_offer(12'h100, 4'd3, 8'd6, "R8");
        expect_offer(12'h101, 4'd2, 8'd4, "R8");
        @(posedge clk); #1 src_line[0] = 1'b1; src_line[1] = 1'b1;
        settle(8, "R8");
        @(posedge clk); #1 src_line[0] = 1'b0; src_line[1] = 1'b0;

        // R9: resend during a scan queues another full scan
        cur_tag = "R9";
        do_rej(12'h100);
        expect_offer(12'h100, 4'd3, 8'd6, "R9");
        expect_offer(12'h100, 4'd3, 8'd6, "R9");
        @(posedge clk); #1 resend_req = 1'b1;
        @(posedge clk); #1 resend_req = 1'b0;
        @(posedge clk); #1 resend_req = 1'b1; rej_valid = 1'b1; rej_num = 12'h100;
        @(posedge clk); #1 resend_req = 1'b0; rej_valid = 1'b0;
        @(negedge clk);
        check(scan_busy == 1'b1, "R9", "scan_busy during scan", scan_busy, 1);
        settle(16, "R9");
        check(scan_busy == 1'b0, "R9", "scan_busy after scans", scan_busy, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule